// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare Interrupts

This block keeps a single 32-bit counter shared by a set of processors. Each processor also has a private compare register, a pending flag, a local mask and a pin-routing register. When the running counter equals a processor's compare value, that processor's pending flag is set. The flag then drives one of the processor's interrupt pins if the compare bit of its local mask is set and its routing register selects a pin.

Software uses one register port. A request carries the identity of the processor that makes it. The shared section holds a configuration word with a halt control, the counter itself, a read-only counter alias meant for unprivileged code, and a high half that always reads as zero. The local section always reaches the requesting processor's own registers. A second, indirect section reaches the processor named in the requester's stored remote index. Software acknowledges a compare interrupt by writing a new compare value.

Top module: `vp_count_compare`

## Requirements
- R1: After reset the counter is 0 and running (config bit 0 reads 0), every compare reads 32'hFFFF_FFFF, every local mask reads 6'h32, every pending word reads 0, every routing word reads 32'h8000_0000, every remote index reads 0, and all pins are low.
- R2: While running, the counter advances by one per clock. Writing config (shared offset 0) bit 0 = 1 halts it and writing 0 resumes it. Config bit 0 reads back the halt state.
- R3: A write to the counter (shared offset 1) loads it only while halted. While running, the write is lost.
- R4: While running, a counter equal to a processor's compare sets its pending bit (bit 1 of local offset 0) at that clock edge, including the edge at which a halt is written.
- R5: Pin p of processor v (`vp_pin_o[v*NUM_PIN+p]`) is high exactly when v is pending, mask bit 1 is set, routing bit 31 is set and routing bits 5:0 equal p.
- R6: Writing local offset 6 (compare) clears pending at that edge and loads the value. A value equal to the counter's next value fires one clock later. A value equal to the counter at the write edge does not fire.
- R7: Writing local offset 2 ORs wdata[5:0] into the mask. Writing local offset 3 clears the mask bits set in wdata[5:0]. Mask reads at local offset 1.
- R8: A routing write (local offset 4) whose bits 5:0 are NUM_PIN or more is ignored entirely.
- R9: Address bits 5:4 = 1 select the requester's own registers and = 2 select the registers of the processor named in the requester's remote index (local offset 5). A remote index write of NUM_VP or more is ignored.
- R10: Shared offset 3 reads the counter and ignores writes. Shared offset 2 and local offset 7 read zero.
- R11: Read data appears on `rsp_data` one clock after the request edge, and gives register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Register request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address: [5:4] section, [3] must be 0, [2:0] offset |
| req_vp | input | VP_W | Index of the requesting processor |
| req_wdata | input | 32 | Write data |
| rsp_data | output | 32 | Read data, registered |
| vp_pin_o | output | NUM_VP*NUM_PIN | Interrupt pins, processor-major |

## Verification
A write lands at the clock edge that accepts it, so its effect shows through a read at the next request or on the pins half a clock later. A read returns the values from before its own edge, so a pending bit set by a match at that edge is still 0 in that read. The bench drives one request per cycle on falling edges and keeps its counter arithmetic in step with that. In the counter tests, readings taken back-to-back differ by exactly one. The compare-versus-next-count case is checked at the read that still shows 0 and again at the following read.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int DW = 32;
  localparam int MASK_W = 6;
  localparam int PIN_FIELD_W = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;
  localparam int CMP_BIT = 1;

  localparam logic [1:0] SEC_SHARED = 2'd0;
  localparam logic [1:0] SEC_LOCAL  = 2'd1;
  localparam logic [1:0] SEC_REMOTE = 2'd2;

  localparam logic [2:0] SH_CFG  = 3'd0;
  localparam logic [2:0] SH_CLO  = 3'd1;
  localparam logic [2:0] SH_CHI  = 3'd2;
  localparam logic [2:0] SH_USER = 3'd3;

  localparam logic [2:0] LO_PEND  = 3'd0;
  localparam logic [2:0] LO_MASK  = 3'd1;
  localparam logic [2:0] LO_SETM  = 3'd2;
  localparam logic [2:0] LO_CLRM  = 3'd3;
  localparam logic [2:0] LO_ROUTE = 3'd4;
  localparam logic [2:0] LO_RIDX  = 3'd5;
  localparam logic [2:0] LO_CMPLO = 3'd6;
  localparam logic [2:0] LO_CMPHI = 3'd7;
endpackage

// File: rtl/vcc_counter.sv
module vcc_counter
  import vcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_wr_en,
  input  logic          halt_wdata,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt_o,
  output logic          run_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          halt_q, halt_d;

  always_comb begin
    halt_d = halt_q;
    if (halt_wr_en) halt_d = halt_wdata;
    cnt_d = cnt_q;
    if (!halt_q)      cnt_d = cnt_q + 1'b1;
    else if (load_en) cnt_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = !halt_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !load_en) |=> $stable(cnt_o));
  p_halt_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_wr_en |=> (run_o == !$past(halt_wdata)));
endmodule

// File: rtl/vcc_vp_slot.sv
module vcc_vp_slot
  import vcc_pkg::*;
#(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  localparam int VP_W   = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DW-1:0]          cnt_i,
  input  logic                   run_i,
  input  logic                   wr_en,
  input  logic [2:0]             wr_off,
  input  logic [DW-1:0]          wdata,
  output logic                   pend_o,
  output logic [MASK_W-1:0]      mask_o,
  output logic                   route_en_o,
  output logic [PIN_FIELD_W-1:0] route_pin_o,
  output logic [DW-1:0]          cmp_o,
  output logic [VP_W-1:0]        ridx_o,
  output logic [NUM_PIN-1:0]     pins_o
);
  localparam logic [PIN_FIELD_W-1:0] PIN_LIM = PIN_FIELD_W'(NUM_PIN);

  logic                   pend_q, pend_d;
  logic [MASK_W-1:0]      mask_q, mask_d;
  logic                   ren_q, ren_d;
  logic [PIN_FIELD_W-1:0] rpin_q, rpin_d;
  logic [DW-1:0]          cmp_q, cmp_d;
  logic [VP_W-1:0]        ridx_q, ridx_d;
  logic                   hit, wr_cmp, wr_route;

  assign hit      = run_i && (cnt_i == cmp_q);
  assign wr_cmp   = wr_en && (wr_off == LO_CMPLO);
  assign wr_route = wr_en && (wr_off == LO_ROUTE);

  always_comb begin
    pend_d = pend_q;
    mask_d = mask_q;
    ren_d  = ren_q;
    rpin_d = rpin_q;
    cmp_d  = cmp_q;
    ridx_d = ridx_q;
    if (wr_cmp) begin
      pend_d = 1'b0;
      cmp_d  = wdata;
    end else if (hit) begin
      pend_d = 1'b1;
    end
    if (wr_en && wr_off == LO_SETM) mask_d = mask_q | wdata[MASK_W-1:0];
    if (wr_en && wr_off == LO_CLRM) mask_d = mask_q & ~wdata[MASK_W-1:0];
    if (wr_route && (wdata[PIN_FIELD_W-1:0] < PIN_LIM)) begin
      ren_d  = wdata[DW-1];
      rpin_d = wdata[PIN_FIELD_W-1:0];
    end
    if (wr_en && wr_off == LO_RIDX && (wdata < DW'(NUM_VP)))
      ridx_d = wdata[VP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= MASK_RST;
      ren_q  <= 1'b1;
      rpin_q <= '0;
      cmp_q  <= '1;
      ridx_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      ren_q  <= ren_d;
      rpin_q <= rpin_d;
      cmp_q  <= cmp_d;
      ridx_q <= ridx_d;
    end
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign pins_o[p] = pend_q && mask_q[CMP_BIT] && ren_q &&
                       (rpin_q == PIN_FIELD_W'(p));
  end

  assign pend_o      = pend_q;
  assign mask_o      = mask_q;
  assign route_en_o  = ren_q;
  assign route_pin_o = rpin_q;
  assign cmp_o       = cmp_q;
  assign ridx_o      = ridx_q;

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !pend_o);
  p_bad_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_route && wdata[PIN_FIELD_W-1:0] >= PIN_LIM) |=>
      ($stable(route_pin_o) && $stable(route_en_o)));
  p_one_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pins_o));
  p_pend_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(run_i && cnt_i == cmp_o));
  p_ridx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ridx_o < VP_W'(NUM_VP)) || (NUM_VP == 2**VP_W));
endmodule

// File: rtl/vp_count_compare.sv
module vp_count_compare
  import vcc_pkg::*;
#(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  localparam int VP_W   = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_vld,
  input  logic                      req_wr,
  input  logic [5:0]                req_addr,
  input  logic [VP_W-1:0]           req_vp,
  input  logic [DW-1:0]             req_wdata,
  output logic [DW-1:0]             rsp_data,
  output logic [NUM_VP*NUM_PIN-1:0] vp_pin_o
);
  logic [1:0]    sec;
  logic [2:0]    off;
  logic          addr_ok, wr, sh_wr, vp_acc;
  logic [DW-1:0] cnt;
  logic          run;
  logic [VP_W-1:0] tgt;
  logic [DW-1:0] rd_d, rsp_q;

  logic                   pend   [NUM_VP];
  logic [MASK_W-1:0]      mask   [NUM_VP];
  logic                   ren    [NUM_VP];
  logic [PIN_FIELD_W-1:0] rpin   [NUM_VP];
  logic [DW-1:0]          cmpv   [NUM_VP];
  logic [VP_W-1:0]        ridx   [NUM_VP];
  logic [NUM_PIN-1:0]     pins   [NUM_VP];

  assign sec     = req_addr[5:4];
  assign off     = req_addr[2:0];
  assign addr_ok = !req_addr[3];
  assign wr      = req_vld && req_wr && addr_ok;
  assign sh_wr   = wr && (sec == SEC_SHARED);
  assign vp_acc  = (sec == SEC_LOCAL) || (sec == SEC_REMOTE);
  assign tgt     = (sec == SEC_REMOTE) ? ridx[req_vp] : req_vp;

  vcc_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_wr_en (sh_wr && off == SH_CFG),
    .halt_wdata (req_wdata[0]),
    .load_en    (sh_wr && off == SH_CLO),
    .load_val   (req_wdata),
    .cnt_o      (cnt),
    .run_o      (run)
  );

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    vcc_vp_slot #(.NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_i       (cnt),
      .run_i       (run),
      .wr_en       (wr && vp_acc && (tgt == VP_W'(v))),
      .wr_off      (off),
      .wdata       (req_wdata),
      .pend_o      (pend[v]),
      .mask_o      (mask[v]),
      .route_en_o  (ren[v]),
      .route_pin_o (rpin[v]),
      .cmp_o       (cmpv[v]),
      .ridx_o      (ridx[v]),
      .pins_o      (pins[v])
    );
    assign vp_pin_o[v*NUM_PIN +: NUM_PIN] = pins[v];
  end

  always_comb begin
    rd_d = '0;
    if (addr_ok && sec == SEC_SHARED) begin
      case (off)
        SH_CFG:  rd_d = {{(DW-1){1'b0}}, !run};
        SH_CLO:  rd_d = cnt;
        SH_USER: rd_d = cnt;
        default: rd_d = '0;
      endcase
    end else if (addr_ok && vp_acc) begin
      case (off)
        LO_PEND:  rd_d = DW'(pend[tgt]) << CMP_BIT;
        LO_MASK:  rd_d = DW'(mask[tgt]);
        LO_ROUTE: rd_d = {ren[tgt], {(DW-1-PIN_FIELD_W){1'b0}}, rpin[tgt]};
        LO_RIDX:  rd_d = DW'(ridx[tgt]);
        LO_CMPLO: rd_d = cmpv[tgt];
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rsp_q <= '0;
    else if (req_vld && !req_wr) rsp_q <= rd_d;
  end

  assign rsp_data = rsp_q;

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && !req_wr) |=> $stable(rsp_data));
endmodule

// File: tb/vp_count_compare_tb_top.sv
module vp_count_compare_tb_top;
  localparam int NV = 4;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_wr = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_vp = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_data;
  logic [NV*NP-1:0] vp_pin_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [5:0]  m_mask [NV];
  logic        m_pend [NV];
  logic        m_ren  [NV];
  logic [5:0]  m_rpin [NV];
  logic [31:0] m_cmp  [NV];

  always #2 clk = ~clk;

  vp_count_compare #(.NUM_VP(NV), .NUM_PIN(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_vp(req_vp), .req_wdata(req_wdata),
    .rsp_data(rsp_data), .vp_pin_o(vp_pin_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus(input logic w, input logic [5:0] a, input logic [1:0] v,
                     input logic [31:0] d);
    req_vld = 1'b1; req_wr = w; req_addr = a; req_vp = v; req_wdata = d;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] v, output logic [31:0] q);
    bus(1'b0, a, v, '0);
    q = rsp_data;
  endtask

  function automatic logic [NV*NP-1:0] exp_pins();
    logic [NV*NP-1:0] r = '0;
    for (int v = 0; v < NV; v++)
      if (m_pend[v] && m_mask[v][1] && m_ren[v] && m_rpin[v] < NP)
        r[v*NP + m_rpin[v]] = 1'b1;
    return r;
  endfunction

  task automatic t_setm(input int v, input logic [31:0] d);
    bus(1'b1, 6'h12, 2'(v), d); m_mask[v] = m_mask[v] | d[5:0];
  endtask
  task automatic t_clrm(input int v, input logic [31:0] d);
    bus(1'b1, 6'h13, 2'(v), d); m_mask[v] = m_mask[v] & ~d[5:0];
  endtask
  task automatic t_route(input int v, input logic [31:0] d);
    bus(1'b1, 6'h14, 2'(v), d);
    if (d[5:0] < NP) begin m_ren[v] = d[31]; m_rpin[v] = d[5:0]; end
  endtask
  task automatic t_cmp(input int v, input logic [31:0] d);
    bus(1'b1, 6'h16, 2'(v), d); m_cmp[v] = d; m_pend[v] = 1'b0;
  endtask
  // counter must be halted on entry; match happens at the halt edge (R4)
  task automatic t_force(input int v, input logic [31:0] x);
    bus(1'b1, 6'h01, 2'd0, x);
    t_cmp(v, x);
    bus(1'b1, 6'h00, 2'd0, 32'd0);
    bus(1'b1, 6'h00, 2'd0, 32'd1);
    for (int k = 0; k < NV; k++) if (m_cmp[k] == x) m_pend[k] = 1'b1;
  endtask

  initial begin
    logic [31:0] q, a, b;
    for (int v = 0; v < NV; v++) begin
      m_mask[v] = 6'h32; m_pend[v] = 0; m_ren[v] = 1; m_rpin[v] = 0; m_cmp[v] = '1;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 pins", 32'(vp_pin_o), 32'd0);
    rd(6'h00, 0, q); chk("R1 cfg", q, 0);
    for (int v = 0; v < NV; v++) begin
      rd(6'h16, 2'(v), q); chk("R1 cmp", q, 32'hFFFF_FFFF);
      rd(6'h11, 2'(v), q); chk("R1 mask", q, 32'h32);
      rd(6'h10, 2'(v), q); chk("R1 pend", q, 0);
      rd(6'h14, 2'(v), q); chk("R1 route", q, 32'h8000_0000);
      rd(6'h15, 2'(v), q); chk("R1 ridx", q, 0);
    end

    // R2 / R11 consecutive reads differ by one; alias too (R10)
    rd(6'h01, 0, a); rd(6'h01, 0, b); chk("R2 step", b - a, 1);
    rd(6'h03, 0, b); chk("R10 alias", b - a, 2);
    // R3 running write discarded
    rd(6'h01, 0, a); bus(1'b1, 6'h01, 0, 32'h1234); rd(6'h01, 0, b);
    chk("R3 run load", b, a + 2);

    // R6 compare equal to next count fires one clock later
    rd(6'h01, 0, a);
    bus(1'b1, 6'h16, 1, a + 2); m_cmp[1] = a + 2;
    rd(6'h10, 1, q); chk("R11 pend pre", q, 0);
    rd(6'h10, 1, q); chk("R6 next fire", q, 2); m_pend[1] = 1;
    chk("R5 pin vp1", 32'(vp_pin_o), 32'(exp_pins()));
    chk("R5 pin vp1 direct", 32'(vp_pin_o), 32'h40);
    rd(6'h01, 0, a);
    bus(1'b1, 6'h16, 0, a + 1); m_cmp[0] = a + 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd(6'h10, 0, q); chk("R6 no fire", q, 0);
    t_cmp(1, 32'hFFFF_FFF0);
    rd(6'h10, 1, q); chk("R6 ack", q, 0);
    chk("R6 pin low", 32'(vp_pin_o), 0);

    // R2 halt, R3 load, R10 alias/high
    bus(1'b1, 6'h00, 0, 32'd1);
    rd(6'h00, 0, q); chk("R2 cfg halt", q, 1);
    rd(6'h01, 0, a); rd(6'h01, 0, b); chk("R2 frozen", b, a);
    bus(1'b1, 6'h01, 0, 32'h100); rd(6'h01, 0, q); chk("R3 halt load", q, 32'h100);
    bus(1'b1, 6'h03, 0, 32'h55); rd(6'h03, 0, q); chk("R10 alias ro", q, 32'h100);
    rd(6'h02, 0, q); chk("R10 hi", q, 0);
    rd(6'h17, 0, q); chk("R10 cmp hi", q, 0);

    // R9 remote window
    bus(1'b1, 6'h15, 0, 32'd2);
    bus(1'b1, 6'h22, 0, 32'h01); m_mask[2] = 6'h33;
    rd(6'h11, 2, q); chk("R9 remote set", q, 32'h33);
    bus(1'b1, 6'h15, 0, 32'd4); rd(6'h15, 0, q); chk("R9 ridx range", q, 2);
    rd(6'h26, 0, q); chk("R9 remote rd", q, m_cmp[2]);
    rd(6'h11, 0, q); chk("R9 local own", q, 32'h32);

    // R4 match at halt edge, R8 bad route
    t_force(2, 32'h700);
    rd(6'h10, 2, q); chk("R4 halt edge match", q, 2);
    t_route(2, 32'h8000_0007);
    rd(6'h14, 2, q); chk("R8 bad pin", q, 32'h8000_0000);
    chk("R5 pins", 32'(vp_pin_o), 32'(exp_pins()));

    // random phase (counter halted)
    for (int i = 0; i < 300; i++) begin
      int v = int'($urandom_range(0, NV-1));
      int op = int'($urandom_range(0, 4));
      logic [31:0] d = $urandom();
      case (op)
        0: t_setm(v, d);
        1: t_clrm(v, d);
        2: t_route(v, {d[31], 23'd0, 5'd0, d[2:0]});
        3: t_cmp(v, {16'hF000, d[15:0]});
        default: t_force(v, {20'd0, d[11:0]});
      endcase
      chk("R5 pins rnd", 32'(vp_pin_o), 32'(exp_pins()));
      v = int'($urandom_range(0, NV-1));
      rd(6'h11, 2'(v), q); chk("R7 mask rnd", q, 32'(m_mask[v]));
      rd(6'h10, 2'(v), q); chk("R4 pend rnd", q, 32'(m_pend[v]) << 1);
      rd(6'h14, 2'(v), q); chk("R8 route rnd", q, {m_ren[v], 25'd0, m_rpin[v]});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule